// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches the bus cycles that the local processor starts and raises an internal bus-error strobe when no response comes back in time. A cycle counts as answered when a data-size acknowledge or an autovector response is sampled. The allowed wait is one of four periods, picked by a two-bit code that is captured when the cycle starts. Cycles that go out to the external bus are watched only while a separate enable is set. Cycles that other bus masters start are never watched. A word transfer to an 8-bit port is timed as one unit across both byte accesses.

The same block holds a halt monitor. When the halt input rises because of a double bus fault and the halt-monitor enable is set, the block sends a one-clock system reset request. It also sets a flag that records that the latest reset came from the halt monitor. The flag survives the reset it records. It is cleared by a reset with any other cause, which arrives on `other_rst_i`, or by the power-on reset `rst_ni`. Either kind of system reset also drops any cycle that is being timed.

Top module: `bus_cycle_monitor`

## Requirements
- R1: With no response, `berr_o` rises after the L-th rising edge that follows the edge where the start strobe was taken. L is 64, 32, 16 or 8 for timeout codes 00, 01, 10 and 11.
- R2: A data-size acknowledge or autovector sampled on any edge up to and including the L-th ends the cycle without a bus error. The monitor then stays quiet until the next start.
- R3: `berr_o` is high for exactly one clock per timed-out cycle. No further pulse follows until a new cycle starts.
- R4: A cycle with `ext_cyc_i`=1 is timed only if `ext_mon_en_i`=1. When `ext_mon_en_i`=0, such a cycle never produces a bus error.
- R5: A cycle started with `local_master_i`=0 is ignored and never produces a bus error.
- R6: For a word transfer (`word_xfer_i`=1) to an 8-bit port (`narrow_port_i`=1), the first data-size acknowledge does not restart the count. The timeout is still measured from the original start, and only the second acknowledge ends the cycle.
- R7: An autovector response ends the cycle at once, even while the first byte of an 8-bit word transfer is still pending.
- R8: The timeout code is sampled only on the start edge. Changing `tmo_sel_i` during a cycle does not move that cycle's timeout.
- R9: If `halt_mon_en_i`=1, a rising edge on `halt_i` gives a `sys_rst_req_o` pulse of exactly one clock. If `halt_mon_en_i`=0, the rising edge gives no request.
- R10: `halt_rst_flag_o` is set together with a halt-monitor reset request and holds through it. It is cleared by `other_rst_i` or `rst_ni`.
- R11: `cyc_end_i` ends a timed cycle without a bus error.
- R12: While and right after `rst_ni` is low, `berr_o`, `sys_rst_req_o` and `halt_rst_flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| cyc_start_i | input | 1 | One-clock strobe marking the start of a bus cycle |
| cyc_end_i | input | 1 | Cycle ended by a terminator other than a response |
| dsack_i | input | 1 | Data-size acknowledge |
| avec_i | input | 1 | Autovector response |
| ext_cyc_i | input | 1 | Current cycle goes to the external bus |
| local_master_i | input | 1 | Current cycle was started by the local processor |
| narrow_port_i | input | 1 | Target port is 8 bits wide |
| word_xfer_i | input | 1 | Transfer is a word |
| halt_i | input | 1 | Halt signalling a double bus fault |
| tmo_sel_i | input | 2 | Timeout code |
| ext_mon_en_i | input | 1 | Enable timing of external cycles |
| halt_mon_en_i | input | 1 | Enable the halt-monitor reset |
| other_rst_i | input | 1 | System reset from a cause other than the halt monitor |
| berr_o | output | 1 | Internal bus-error strobe |
| sys_rst_req_o | output | 1 | Reset request from the halt monitor |
| halt_rst_flag_o | output | 1 | Latest reset came from the halt monitor |

## Verification
The assertions rely on two things from the bus master. A start strobe comes only when no cycle is being timed, or as the second byte access of a split word. Responses, ends and resets are inputs that the checker can observe. The bench drives one cycle at a time and leaves idle clocks between cycles. It drives `halt_i` low whenever it raises `other_rst_i`, so every clearing reset has a cause that is plainly not the halt monitor.

// File: rtl/bus_mon_pkg.sv
package bus_mon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LAST  = 2'd1,
        PH_FIRST = 2'd2
    } bm_phase_e;

    typedef struct packed {
        logic prev_halt;
        logic req;
        logic flag;
    } halt_state_t;

    function automatic int unsigned period_of(input int unsigned base, input int unsigned code);
        return base >> code;
    endfunction

endpackage

// File: rtl/bus_mon_period.sv
module bus_mon_period #(
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned BASE_PERIOD = 64,
    localparam int unsigned LIM_W      = $clog2(BASE_PERIOD) + 1,
    localparam int unsigned NUM_CODES  = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [LIM_W-1:0] limit_o
);
    logic [LIM_W-1:0] tab [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign tab[g] = LIM_W'(bus_mon_pkg::period_of(BASE_PERIOD, g));
    end

    assign limit_o = tab[sel_i];
endmodule

// File: rtl/bus_mon_timer.sv
module bus_mon_timer #(
    parameter int unsigned CNT_W = 6,
    localparam int unsigned LIM_W = CNT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             split_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             dsack_i,
    input  logic             avec_i,
    input  logic             abort_i,
    input  logic             clr_i,
    output logic             berr_o
);
    import bus_mon_pkg::*;

    typedef struct packed {
        bm_phase_e        phase;
        logic [CNT_W-1:0] cnt;
        logic [LIM_W-1:0] lim;
        logic             berr;
    } tmr_state_t;

    tmr_state_t state_d, state_q;
    logic       expire;

    assign expire = ({1'b0, state_q.cnt} == (state_q.lim - 1'b1));

    always_comb begin
        state_d      = state_q;
        state_d.berr = 1'b0;
        if (clr_i) begin
            state_d.phase = PH_IDLE;
            state_d.cnt   = '0;
        end else begin
            case (state_q.phase)
                PH_IDLE: begin
                    if (start_i) begin
                        state_d.phase = split_i ? PH_FIRST : PH_LAST;
                        state_d.cnt   = '0;
                        state_d.lim   = limit_i;
                    end
                end
                default: begin
                    if (abort_i || avec_i) begin
                        state_d.phase = PH_IDLE;
                        state_d.cnt   = '0;
                    end else if (dsack_i && state_q.phase == PH_LAST) begin
                        state_d.phase = PH_IDLE;
                        state_d.cnt   = '0;
                    end else if (expire) begin
                        state_d.phase = PH_IDLE;
                        state_d.cnt   = '0;
                        state_d.berr  = 1'b1;
                    end else begin
                        state_d.cnt = state_q.cnt + 1'b1;
                        if (dsack_i) begin
                            state_d.phase = PH_LAST;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{phase: PH_IDLE, cnt: '0, lim: '0, berr: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign berr_o = state_q.berr;
endmodule

// File: rtl/bus_mon_halt.sv
module bus_mon_halt (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic halt_i,
    input  logic enable_i,
    input  logic other_rst_i,
    output logic req_o,
    output logic flag_o
);
    import bus_mon_pkg::*;

    halt_state_t state_d, state_q;

    always_comb begin
        state_d           = state_q;
        state_d.prev_halt = halt_i;
        state_d.req       = halt_i && !state_q.prev_halt && enable_i;
        if (state_d.req) begin
            state_d.flag = 1'b1;
        end else if (other_rst_i) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_o  = state_q.req;
    assign flag_o = state_q.flag;
endmodule

// File: rtl/bus_cycle_monitor.sv
module bus_cycle_monitor #(
    parameter int unsigned SEL_W       = 2,
    parameter int unsigned BASE_PERIOD = 64,
    localparam int unsigned CNT_W      = $clog2(BASE_PERIOD),
    localparam int unsigned LIM_W      = CNT_W + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cyc_start_i,
    input  logic             cyc_end_i,
    input  logic             dsack_i,
    input  logic             avec_i,
    input  logic             ext_cyc_i,
    input  logic             local_master_i,
    input  logic             narrow_port_i,
    input  logic             word_xfer_i,
    input  logic             halt_i,
    input  logic [SEL_W-1:0] tmo_sel_i,
    input  logic             ext_mon_en_i,
    input  logic             halt_mon_en_i,
    input  logic             other_rst_i,
    output logic             berr_o,
    output logic             sys_rst_req_o,
    output logic             halt_rst_flag_o
);
    logic [LIM_W-1:0] limit;
    logic             start_ok;
    logic             split_word;
    logic             cyc_clr;

    // Only locally started cycles qualify; external ones need their enable.
    assign start_ok   = cyc_start_i && local_master_i && (!ext_cyc_i || ext_mon_en_i);
    assign split_word = narrow_port_i && word_xfer_i;
    assign cyc_clr    = other_rst_i || sys_rst_req_o;

    bus_mon_period #(
        .SEL_W       (SEL_W),
        .BASE_PERIOD (BASE_PERIOD)
    ) period_i (
        .sel_i   (tmo_sel_i),
        .limit_o (limit)
    );

    bus_mon_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_ok),
        .split_i (split_word),
        .limit_i (limit),
        .dsack_i (dsack_i),
        .avec_i  (avec_i),
        .abort_i (cyc_end_i),
        .clr_i   (cyc_clr),
        .berr_o  (berr_o)
    );

    bus_mon_halt halt_i0 (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .halt_i      (halt_i),
        .enable_i    (halt_mon_en_i),
        .other_rst_i (other_rst_i),
        .req_o       (sys_rst_req_o),
        .flag_o      (halt_rst_flag_o)
    );
endmodule

// File: rtl/bus_cycle_monitor_chk.sv
module bus_cycle_monitor_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cyc_end_i,
    input logic avec_i,
    input logic halt_i,
    input logic halt_mon_en_i,
    input logic other_rst_i,
    input logic berr_o,
    input logic sys_rst_req_o,
    input logic halt_rst_flag_o
);
    p_berr_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        berr_o |=> !berr_o);

    p_no_berr_after_avec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        berr_o |-> !$past(avec_i));

    p_no_berr_after_end_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        berr_o |-> !$past(cyc_end_i));

    p_req_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_req_o |=> !sys_rst_req_o);

    p_req_needs_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_req_o |-> ($past(halt_mon_en_i) && $past(halt_i)));

    p_flag_with_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_req_o |-> halt_rst_flag_o);

    p_flag_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (other_rst_i && !halt_i) |=> !halt_rst_flag_o);
endmodule

bind bus_cycle_monitor bus_cycle_monitor_chk chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cyc_end_i       (cyc_end_i),
    .avec_i          (avec_i),
    .halt_i          (halt_i),
    .halt_mon_en_i   (halt_mon_en_i),
    .other_rst_i     (other_rst_i),
    .berr_o          (berr_o),
    .sys_rst_req_o   (sys_rst_req_o),
    .halt_rst_flag_o (halt_rst_flag_o)
);

// File: tb/bus_cycle_monitor_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 0, cyc_end = 0, dsack = 0, avec = 0;
    logic       ext_cyc = 0, local_m = 1, narrow = 0, word = 0;
    logic       halt = 0, ext_en = 0, halt_en = 0, other_rst = 0;
    logic [1:0] tsel = 2'b00;
    logic       berr, req, flag;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    bus_cycle_monitor dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc_start), .cyc_end_i(cyc_end),
        .dsack_i(dsack), .avec_i(avec), .ext_cyc_i(ext_cyc), .local_master_i(local_m),
        .narrow_port_i(narrow), .word_xfer_i(word), .halt_i(halt), .tmo_sel_i(tsel),
        .ext_mon_en_i(ext_en), .halt_mon_en_i(halt_en), .other_rst_i(other_rst),
        .berr_o(berr), .sys_rst_req_o(req), .halt_rst_flag_o(flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One bus cycle; k counts edges after the start edge. exp_k=0: never.
    task automatic run_cycle(input string tag, input logic [1:0] sel, input logic ext,
                             input logic loc, input logic nar, input logic wrd,
                             input int dk1, input int dk2, input int avk, input int endk,
                             input int chgk, input logic [1:0] chg_sel, input int exp_k);
        int first_hi = 0;
        int highs = 0;
        @(negedge clk);
        tsel = sel; ext_cyc = ext; local_m = loc; narrow = nar; word = wrd;
        cyc_start = 1'b1;
        @(posedge clk); #1;
        for (int k = 1; k <= 80; k++) begin
            @(negedge clk);
            cyc_start = 1'b0;
            dsack     = (k == dk1) || (k == dk2);
            avec      = (k == avk);
            cyc_end   = (k == endk);
            if (k == chgk) tsel = chg_sel;
            @(posedge clk); #1;
            if (berr) begin
                highs++;
                if (first_hi == 0) first_hi = k;
            end
        end
        @(negedge clk);
        dsack = 0; avec = 0; cyc_end = 0; ext_cyc = 0; local_m = 1; narrow = 0; word = 0;
        check({tag, " berr edge"}, first_hi, exp_k);
        check({tag, " berr pulses R3"}, highs, (exp_k == 0) ? 0 : 1);
    endtask

    task automatic t_reset_state();
        check("R12 berr at reset", int'(berr), 0);
        check("R12 req at reset", int'(req), 0);
        check("R12 flag at reset", int'(flag), 0);
    endtask

    task automatic t_periods();
        run_cycle("R1 code00", 2'b00, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 64);
        run_cycle("R1 code01", 2'b01, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 32);
        run_cycle("R1 code10", 2'b10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 16);
        run_cycle("R1 code11", 2'b11, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 8);
    endtask

    task automatic t_responses();
        run_cycle("R2 dsack at limit", 2'b11, 0, 1, 0, 0, 8, 0, 0, 0, 0, 2'b00, 0);
        run_cycle("R2 dsack early", 2'b10, 0, 1, 0, 0, 3, 0, 0, 0, 0, 2'b00, 0);
        run_cycle("R2 avec early", 2'b01, 0, 1, 0, 0, 0, 0, 5, 0, 0, 2'b00, 0);
    endtask

    task automatic t_external();
        ext_en = 1'b0;
        run_cycle("R4 ext disabled", 2'b10, 1, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0);
        ext_en = 1'b1;
        run_cycle("R4 ext enabled", 2'b10, 1, 1, 0, 0, 0, 0, 0, 0, 0, 2'b00, 16);
        ext_en = 1'b0;
    endtask

    task automatic t_foreign_master();
        run_cycle("R5 other master", 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, 0);
    endtask

    task automatic t_split_word();
        run_cycle("R6 first ack only", 2'b10, 0, 1, 1, 1, 5, 0, 0, 0, 0, 2'b00, 16);
        run_cycle("R6 both acks", 2'b10, 0, 1, 1, 1, 5, 16, 0, 0, 0, 2'b00, 0);
        run_cycle("R6 byte port single", 2'b11, 0, 1, 1, 0, 4, 0, 0, 0, 0, 2'b00, 0);
    endtask

    task automatic t_avec_split();
        run_cycle("R7 avec on split", 2'b11, 0, 1, 1, 1, 0, 0, 3, 0, 0, 2'b00, 0);
    endtask

    task automatic t_code_change();
        run_cycle("R8 code change", 2'b11, 0, 1, 0, 0, 0, 0, 0, 0, 2, 2'b00, 8);
    endtask

    task automatic t_abort();
        run_cycle("R11 end abort", 2'b11, 0, 1, 0, 0, 0, 0, 0, 4, 0, 2'b00, 0);
    endtask

    task automatic t_halt();
        int seen = 0;
        halt_en = 1'b0;
        @(negedge clk); halt = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            if (req) seen++;
        end
        check("R9 halt disabled no request", seen, 0);
        check("R10 flag stays clear", int'(flag), 0);
        @(negedge clk); halt = 1'b0;
        halt_en = 1'b1;
        @(negedge clk); halt = 1'b1;
        @(posedge clk); #1;
        check("R9 request raised", int'(req), 1);
        check("R10 flag set", int'(flag), 1);
        @(posedge clk); #1;
        check("R9 request one clock", int'(req), 0);
        check("R10 flag held", int'(flag), 1);
        @(negedge clk); halt = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 flag still held", int'(flag), 1);
        @(negedge clk); other_rst = 1'b1;
        @(posedge clk); #1;
        check("R10 flag cleared by other reset", int'(flag), 0);
        @(negedge clk); other_rst = 1'b0;
        halt_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset_state();
        t_periods();
        t_responses();
        t_external();
        t_foreign_master();
        t_split_word();
        t_avec_split();
        t_code_change();
        t_abort();
        t_halt();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule